// File: doc/BRIEF.md
# Indexed-Register Interrupt Redirection Controller

This block routes a small, fixed set of interrupt input pins (eight by default) to interrupt messages. Every pin has a 64-bit routing entry that sets its vector, its delivery mode, physical or logical destination addressing, its destination, its input polarity, whether it is edge or level triggered, and whether it is masked. The controller samples each pin under its own entry. It picks the lowest-numbered pin that has a request and sends one message at a time on a valid/ready output.

Software never addresses a register directly. It writes a register number into a select word at byte offset 0x00 of a 32-bit window. It then reads or writes the data word at byte offset 0x10. The select word keeps its value after any data access, so a read-modify-write can reuse it. Besides the routing entries there are an identity word, a read-only version word, an arbitration word and a boot word.

Level-triggered pins carry an in-service bit. The bit is set when that pin's message is accepted and it blocks further requests from the pin. An end-of-interrupt strobe that carries a vector clears the bit in every level-triggered entry whose vector matches. Back-pressure rules on the message port: once `msg_valid` rises, it and every payload field hold steady until a cycle with `msg_ready` high. The transfer completes in that cycle. `msg_valid` is then low for at least one cycle before the next message. A message that is waiting is never withdrawn, even if software changes its entry.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: A write at byte offset 0x00 loads the select word from data bits 7:0, and a read there returns it zero-extended. Reads and writes at offset 0x10 act on the register the select word names. Any other offset reads as zero and ignores writes. With no read strobe, `bus_rdata` is zero.
- R2: Data reads and data writes leave the select word unchanged. Consecutive data writes without a new select write all reach the same register, and writing the select word again before a data write also works.
- R3: Register 0 holds a writable 8-bit identity in bits 31:24 and writable flags in bits 15 and 14. Its other bits read as zero, and all of it resets to zero.
- R4: Register 1 is read-only. It reads the version parameter (default 0x11) in bits 7:0, a capability flag parameter (default 1) in bit 15 and the pin count minus one in bits 23:16. The default value is therefore 0x0007_8011.
- R5: Register 2 holds a writable 4-bit field in bits 27:24 and register 3 a writable bit 0, both resetting to zero. Register numbers outside 0..3 and outside the routing table read as zero and ignore writes.
- R6: Pin n's entry is register 0x10+2n for the low word and 0x11+2n for the high word. Low-word bits are: vector 7:0, mode 10:8, logical addressing 11, delivery status 12, polarity 13, in-service 14, level trigger 15, mask 16. The high word holds the destination in bits 31:24. Bits 12 and 14 ignore writes. After reset every entry reads 0x0001_0000 (low) and 0 (high).
- R7: For an edge-triggered pin, the active level is high with polarity 0 and low with polarity 1. Each inactive-to-active transition of the registered pin produces exactly one message, and holding the pin active produces no more.
- R8: A level-triggered pin requests while it is active and its in-service bit is clear. Acceptance of its message sets the bit, which then reads as 1 in bit 14.
- R9: A masked pin produces no message. An edge that arrives while the pin is masked is discarded and does not produce a message when the mask is later cleared.
- R10: An entry whose mode is 3 or 6 never produces a message.
- R11: An end-of-interrupt strobe clears the in-service bit of every level-triggered entry whose vector equals `eoi_vector`; entries with other vectors keep theirs. If acceptance of a pin's message and a matching strobe fall in the same cycle, the bit ends up set.
- R12: Delivery status (bit 12) reads 1 exactly while the pin has a request that has not yet been accepted.
- R13: When several pins request at once, the lowest-numbered one is sent first.
- R14: `msg_valid` and the payload stay stable while `msg_ready` is low. After a transfer `msg_valid` drops for at least one cycle. The payload carries the entry's vector, mode and addressing bit. The destination is all eight destination bits in logical addressing, and only bits 3:0 (upper bits zero) in physical addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Window access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_pin | input | NPINS | Interrupt input pins |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | 1 logical, 0 physical addressing |
| msg_dest | output | 8 | Message destination |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |

## Verification
Acceptance of a level-triggered pin's message and an end-of-interrupt strobe for that same vector can land in one cycle. One sets the in-service bit and the other clears it. The bench holds the message with `msg_ready` low. It then raises `msg_ready` and the strobe on the same clock edge. It judges the outcome by reading bit 14 back through the window and by confirming that no second message follows while the pin stays active. A cycle-accurate behavioural model also tracks software writes that land in the same cycle as a message being captured. The message must carry the entry as it stood before the write.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  typedef struct packed {
    logic [7:0] vec;
    logic [2:0] dmode;
    logic       logical;
    logic       pol;
    logic       level;
    logic       masked;
    logic [7:0] dest;
  } route_t;

  localparam logic [7:0] SEL_IDENT = 8'h00;
  localparam logic [7:0] SEL_VERS  = 8'h01;
  localparam logic [7:0] SEL_ARB   = 8'h02;
  localparam logic [7:0] SEL_BOOT  = 8'h03;
  localparam logic [7:0] SEL_TBL   = 8'h10;

  function automatic logic mode_ok(input logic [2:0] m);
    return !((m == 3'd3) || (m == 3'd6));
  endfunction

endpackage

// File: rtl/irq_pin_stage.sv
module irq_pin_stage
  import irq_redir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  route_t     cfg,
  input  logic       taken,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  output logic       req,
  output logic       in_svc
);

  logic s1, s2, epend, svc_q;
  logic act_now, act_old, elig, edge_hit, eoi_hit;
  logic unused_cfg;

  assign unused_cfg = ^{cfg.dest, cfg.logical};

  assign act_now  = s1 ^ cfg.pol;
  assign act_old  = s2 ^ cfg.pol;
  assign elig     = !cfg.masked && mode_ok(cfg.dmode);
  assign edge_hit = elig && !cfg.level && act_now && !act_old;
  assign eoi_hit  = eoi_valid && cfg.level && (cfg.vec == eoi_vector);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      epend <= 1'b0;
      svc_q <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      if (edge_hit)   epend <= 1'b1;
      else if (taken) epend <= 1'b0;
      if (taken && cfg.level) svc_q <= 1'b1;
      else if (eoi_hit)       svc_q <= 1'b0;
    end
  end

  assign req    = elig && (cfg.level ? (act_now && !svc_q) : epend);
  assign in_svc = svc_q;

  // R8: acceptance of a level request marks it in service
  p_svc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cfg.level) |=> in_svc);

  // R11: matching end-of-interrupt without acceptance clears it
  p_eoi_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !taken) |=> !in_svc);

  // R7: an accepted edge leaves no residue unless a fresh edge came
  p_edge_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !edge_hit && !cfg.level) |=> !epend);

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter  int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);

  logic [N-1:0] lower;

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end

  always_comb begin
    lower = (N'(1) << idx) - N'(1);
    if (any) begin
      // R13: chosen pin requests and no lower pin does
      p_pick_lowest_r13: assert (req[idx] && ((req & lower) == '0));
    end
  end

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter  int         N        = 8,
  parameter  int         ADDR_W   = 8,
  parameter  logic [7:0] VERSION  = 8'h11,
  parameter  logic       VER_FLAG = 1'b1,
  localparam int         SW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N-1:0]      pend,
  input  logic [N-1:0]      in_svc,
  output route_t [N-1:0]    cfg
);

  localparam logic [8:0]        TBL_END  = 9'(16 + 2 * N);
  localparam logic [ADDR_W-1:0] OFS_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(16);

  logic [7:0]    sel_q, id_q, off;
  logic          fl_a_q, fl_b_q, boot_q;
  logic [3:0]    arb_q;
  logic          in_tbl, hi_word, wr_sel, wr_dat, rd_en;
  logic [SW-1:0] ent;
  logic [31:0]   word;
  logic          unused_wd;

  assign unused_wd = ^bus_wdata[23:17];

  assign off     = sel_q - SEL_TBL;
  assign in_tbl  = (sel_q >= SEL_TBL) && ({1'b0, sel_q} < TBL_END);
  assign hi_word = sel_q[0];
  assign ent     = off[SW:1];
  assign wr_sel  = bus_sel && bus_wr && (bus_addr == OFS_SEL);
  assign wr_dat  = bus_sel && bus_wr && (bus_addr == OFS_DATA);
  assign rd_en   = bus_sel && !bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      id_q   <= '0;
      fl_a_q <= 1'b0;
      fl_b_q <= 1'b0;
      arb_q  <= '0;
      boot_q <= 1'b0;
    end else begin
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_dat) begin
        if (sel_q == SEL_IDENT) begin
          id_q   <= bus_wdata[31:24];
          fl_a_q <= bus_wdata[15];
          fl_b_q <= bus_wdata[14];
        end
        if (sel_q == SEL_ARB)  arb_q  <= bus_wdata[27:24];
        if (sel_q == SEL_BOOT) boot_q <= bus_wdata[0];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[g] <= '{vec: 8'h0, dmode: 3'h0, logical: 1'b0, pol: 1'b0,
                    level: 1'b0, masked: 1'b1, dest: 8'h0};
      end else if (wr_dat && in_tbl && (ent == SW'(g))) begin
        if (hi_word) begin
          cfg[g].dest <= bus_wdata[31:24];
        end else begin
          cfg[g].vec     <= bus_wdata[7:0];
          cfg[g].dmode   <= bus_wdata[10:8];
          cfg[g].logical <= bus_wdata[11];
          cfg[g].pol     <= bus_wdata[13];
          cfg[g].level   <= bus_wdata[15];
          cfg[g].masked  <= bus_wdata[16];
        end
      end
    end
  end

  always_comb begin
    word = '0;
    if (sel_q == SEL_IDENT)
      word = {id_q, 8'h0, fl_a_q, fl_b_q, 14'h0};
    else if (sel_q == SEL_VERS)
      word = {8'h0, 8'(N - 1), VER_FLAG, 7'h0, VERSION};
    else if (sel_q == SEL_ARB)
      word = {4'h0, arb_q, 24'h0};
    else if (sel_q == SEL_BOOT)
      word = {31'h0, boot_q};
    else if (in_tbl) begin
      if (hi_word)
        word = {cfg[ent].dest, 24'h0};
      else
        word = {15'h0, cfg[ent].masked, cfg[ent].level, in_svc[ent],
                cfg[ent].pol, pend[ent], cfg[ent].logical,
                cfg[ent].dmode, cfg[ent].vec};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en && (bus_addr == OFS_SEL))       bus_rdata = {24'h0, sel_q};
    else if (rd_en && (bus_addr == OFS_DATA)) bus_rdata = word;
  end

  // R2: a data access never moves the select word
  p_sel_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_addr == OFS_DATA)) |=> $stable(sel_q));

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irq_redir_pkg::*;
#(
  parameter  int         NPINS    = 8,
  parameter  int         ADDR_W   = 8,
  parameter  logic [7:0] VERSION  = 8'h11,
  parameter  logic       VER_FLAG = 1'b1,
  localparam int         SW       = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  irq_pin,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_logical,
  output logic [7:0]        msg_dest,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector
);

  route_t [NPINS-1:0] cfg;
  logic   [NPINS-1:0] pend, in_svc;
  logic               pick_any, accept;
  logic   [SW-1:0]    pick_idx, held_pin;

  irq_redir_regs #(.N(NPINS), .ADDR_W(ADDR_W), .VERSION(VERSION),
                   .VER_FLAG(VER_FLAG)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend), .in_svc(in_svc), .cfg(cfg)
  );

  assign accept = msg_valid && msg_ready;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    irq_pin_stage u_stage (
      .clk(clk), .rst_n(rst_n), .pin(irq_pin[g]), .cfg(cfg[g]),
      .taken(accept && (held_pin == SW'(g))),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .req(pend[g]), .in_svc(in_svc[g])
    );
  end

  irq_pick #(.N(NPINS)) u_pick (.req(pend), .any(pick_any), .idx(pick_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid   <= 1'b0;
      held_pin    <= '0;
      msg_vector  <= '0;
      msg_mode    <= '0;
      msg_logical <= 1'b0;
      msg_dest    <= '0;
    end else if (!msg_valid) begin
      if (pick_any) begin
        msg_valid   <= 1'b1;
        held_pin    <= pick_idx;
        msg_vector  <= cfg[pick_idx].vec;
        msg_mode    <= cfg[pick_idx].dmode;
        msg_logical <= cfg[pick_idx].logical;
        msg_dest    <= cfg[pick_idx].logical ? cfg[pick_idx].dest
                                             : {4'h0, cfg[pick_idx].dest[3:0]};
      end
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R14: offered message holds under back-pressure
  p_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid &&
      $stable({msg_vector, msg_mode, msg_logical, msg_dest})));

  // R14: one cycle without valid after every transfer
  p_gap_r14: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !msg_valid);

  // R10: reserved modes never reach the output
  p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> mode_ok(msg_mode));

endmodule

// File: tb/irq_redirect_ctrl_test.sv
module irq_redirect_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NP    = 8;
  localparam int WD    = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] irq_pin = '0;
  logic        msg_valid, msg_ready = 1'b1, msg_logical;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_mode;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;

  int    n_chk = 0, n_bad = 0, hs_cnt = 0;
  bit    done = 0;
  string tag = "R6";

  irq_redirect_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin(irq_pin), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_logical(msg_logical),
    .msg_dest(msg_dest), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  always #(CLK_P / 2) clk = ~clk;

  // behavioural reference model
  bit [7:0] m_sel, m_id, m_vec[NP], m_dst[NP];
  bit       m_fa, m_fb, m_boot;
  bit [3:0] m_arb;
  bit [2:0] m_dm[NP];
  bit m_lg[NP], m_pol[NP], m_lvl[NP], m_msk[NP], m_svc[NP], m_ep[NP];
  bit m_s1[NP], m_s2[NP], n_ep[NP], n_svc[NP], m_req[NP];
  bit       m_ov, m_acc, a1, a2, eh, ac;
  int       m_op, pickn;
  bit [7:0] m_ovec, m_odst;
  bit [2:0] m_odm;
  bit       m_olg;

  function automatic bit m_elig(int n);
    return !m_msk[n] && m_dm[n] != 3 && m_dm[n] != 6;
  endfunction

  function automatic bit m_pend(int n);
    if (!m_elig(n)) return 0;
    if (m_lvl[n]) return (m_s1[n] ^ m_pol[n]) && !m_svc[n];
    return m_ep[n];
  endfunction

  function automatic logic [31:0] m_word();
    int e;
    if (m_sel == 0) return {m_id, 8'h0, m_fa, m_fb, 14'h0};
    if (m_sel == 1) return 32'h0007_8011;
    if (m_sel == 2) return {4'h0, m_arb, 24'h0};
    if (m_sel == 3) return {31'h0, m_boot};
    if (m_sel < 8'h10 || m_sel >= 8'h10 + 2 * NP) return 0;
    e = (m_sel - 8'h10) / 2;
    if (m_sel[0]) return {m_dst[e], 24'h0};
    return {15'h0, m_msk[e], m_lvl[e], m_svc[e], m_pol[e], m_pend(e),
            m_lg[e], m_dm[e], m_vec[e]};
  endfunction

  function automatic logic [31:0] m_rd();
    if (!bus_sel || bus_wr) return 0;
    if (bus_addr == 8'h00) return {24'h0, m_sel};
    if (bus_addr == 8'h10) return m_word();
    return 0;
  endfunction

  task automatic m_reset();
    m_sel = 0; m_id = 0; m_fa = 0; m_fb = 0; m_arb = 0; m_boot = 0;
    m_ov = 0; m_op = 0; m_ovec = 0; m_odm = 0; m_olg = 0; m_odst = 0;
    for (int n = 0; n < NP; n++) begin
      m_vec[n] = 0; m_dm[n] = 0; m_lg[n] = 0; m_pol[n] = 0; m_lvl[n] = 0;
      m_msk[n] = 1; m_dst[n] = 0; m_svc[n] = 0; m_ep[n] = 0;
      m_s1[n] = 0; m_s2[n] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      m_acc = m_ov && msg_ready;
      for (int n = 0; n < NP; n++) begin
        m_req[n] = m_pend(n);
        a1 = m_s1[n] ^ m_pol[n];
        a2 = m_s2[n] ^ m_pol[n];
        eh = m_elig(n) && !m_lvl[n] && a1 && !a2;
        ac = m_acc && (m_op == n);
        n_ep[n] = eh ? 1'b1 : (ac ? 1'b0 : m_ep[n]);
        if (ac && m_lvl[n]) n_svc[n] = 1;
        else if (eoi_valid && m_lvl[n] && m_vec[n] == eoi_vector) n_svc[n] = 0;
        else n_svc[n] = m_svc[n];
      end
      if (!m_ov) begin
        pickn = -1;
        for (int n = NP - 1; n >= 0; n--) if (m_req[n]) pickn = n;
        if (pickn >= 0) begin
          m_ov = 1; m_op = pickn; m_ovec = m_vec[pickn]; m_odm = m_dm[pickn];
          m_olg = m_lg[pickn];
          m_odst = m_lg[pickn] ? m_dst[pickn] : {4'h0, m_dst[pickn][3:0]};
        end
      end else if (msg_ready) m_ov = 0;
      for (int n = 0; n < NP; n++) begin
        m_ep[n] = n_ep[n]; m_svc[n] = n_svc[n];
        m_s2[n] = m_s1[n]; m_s1[n] = irq_pin[n];
      end
      if (bus_sel && bus_wr && bus_addr == 8'h10) begin
        if (m_sel == 0) begin
          m_id = bus_wdata[31:24]; m_fa = bus_wdata[15]; m_fb = bus_wdata[14];
        end else if (m_sel == 2) m_arb = bus_wdata[27:24];
        else if (m_sel == 3) m_boot = bus_wdata[0];
        else if (m_sel >= 8'h10 && m_sel < 8'h10 + 2 * NP) begin
          pickn = (m_sel - 8'h10) / 2;
          if (m_sel[0]) m_dst[pickn] = bus_wdata[31:24];
          else begin
            m_vec[pickn] = bus_wdata[7:0]; m_dm[pickn] = bus_wdata[10:8];
            m_lg[pickn] = bus_wdata[11]; m_pol[pickn] = bus_wdata[13];
            m_lvl[pickn] = bus_wdata[15]; m_msk[pickn] = bus_wdata[16];
          end
        end
      end
      if (bus_sel && bus_wr && bus_addr == 8'h00) m_sel = bus_wdata[7:0];
    end
  end

  task automatic chk(logic [31:0] got, logic [31:0] exp, string t);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P / 4);
    if (rst_n && !done) begin
      chk({8'h0, msg_valid, msg_valid ? {msg_vector, msg_mode, msg_logical, msg_dest} : 20'h0},
          {8'h0, m_ov, m_ov ? {m_ovec, m_odm, m_olg, m_odst} : 20'h0}, {tag, " msg"});
      chk(bus_rdata, m_rd(), {tag, " rdata"});
      if (msg_valid && msg_ready) hs_cnt++;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic wreg(logic [7:0] i, logic [31:0] d);
    wr(8'h00, {24'h0, i}); wr(8'h10, d);
  endtask

  task automatic rd_at(logic [7:0] a, logic [31:0] exp, string t);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 chk(bus_rdata, exp, t);
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rreg(logic [7:0] i, logic [31:0] exp, string t);
    wr(8'h00, {24'h0, i}); rd_at(8'h10, exp, t);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int p);
    @(negedge clk); irq_pin[p] = 1; idle(3); irq_pin[p] = 0;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int h;
    idle(3);
    chk({31'h0, msg_valid}, 0, "R6 reset valid");
    @(negedge clk); rst_n = 1;
    tag = "R6";
    rreg(8'h10, 32'h0001_0000, "R6 reset low");
    rreg(8'h1F, 32'h0, "R6 reset high");
    tag = "R4";
    rreg(8'h01, 32'h0007_8011, "R4 version");
    wreg(8'h01, 32'hFFFF_FFFF);
    rreg(8'h01, 32'h0007_8011, "R4 read-only");
    tag = "R3";
    wreg(8'h00, 32'hFFFF_FFFF);
    rreg(8'h00, 32'hFF00_C000, "R3 ident");
    tag = "R5";
    wreg(8'h02, 32'hFFFF_FFFF); rreg(8'h02, 32'h0F00_0000, "R5 arb");
    wreg(8'h03, 32'hFFFF_FFFF); rreg(8'h03, 32'h1, "R5 boot");
    wreg(8'h05, 32'hFFFF_FFFF); rreg(8'h05, 32'h0, "R5 gap");
    wreg(8'h20, 32'hFFFF_FFFF); rreg(8'h20, 32'h0, "R5 past table");
    tag = "R1";
    wr(8'h00, 32'h0000_0012);
    rd_at(8'h00, 32'h12, "R1 select readback");
    wr(8'h04, 32'hFFFF_FFFF);
    rd_at(8'h04, 32'h0, "R1 other offset");
    rd_at(8'h00, 32'h12, "R1 other offset no effect");
    tag = "R2";
    wr(8'h00, 32'h13);
    wr(8'h10, 32'h5A00_0000);
    rd_at(8'h10, 32'h5A00_0000, "R2 first");
    wr(8'h10, 32'h3C00_0000);
    rd_at(8'h10, 32'h3C00_0000, "R2 rewrite keeps select");
    tag = "R6";
    wreg(8'h12, 32'h0001_5000);
    rreg(8'h12, 32'h0001_0000, "R6 status bits read-only");

    tag = "R7";
    wreg(8'h11, 32'hA500_0000);
    wreg(8'h10, 32'h0000_0030);
    h = hs_cnt;
    @(negedge clk); irq_pin[0] = 1; idle(12);
    chk(hs_cnt - h, 1, "R7 one message per edge");
    irq_pin[0] = 0; idle(4);

    tag = "R13";
    wreg(8'h12, 32'h0000_0031);
    wreg(8'h15, 32'h7700_0000);
    wreg(8'h14, 32'h0000_0932);
    @(negedge clk); msg_ready = 0; irq_pin[1] = 1; irq_pin[2] = 1;
    idle(6);
    chk({24'h0, msg_vector}, 32'h31, "R13 lowest first");
    tag = "R12";
    rreg(8'h14, 32'h0000_1932, "R12 status while waiting");
    tag = "R14";
    idle(3);
    @(negedge clk); msg_ready = 1; irq_pin[1] = 0; irq_pin[2] = 0;
    idle(8);
    tag = "R12";
    rreg(8'h14, 32'h0000_0932, "R12 status after accept");

    tag = "R8";
    h = hs_cnt;
    wreg(8'h17, 32'h9C00_0000);
    wreg(8'h16, 32'h0000_A841);
    idle(8);
    chk(hs_cnt - h, 1, "R8 single level message");
    rreg(8'h16, 32'h0000_E841, "R8 in-service set");
    tag = "R11";
    h = hs_cnt;
    @(negedge clk); eoi_valid = 1; eoi_vector = 8'h42;
    @(negedge clk); eoi_valid = 0; idle(6);
    chk(hs_cnt - h, 0, "R11 other vector ignored");
    @(negedge clk); eoi_valid = 1; eoi_vector = 8'h41;
    @(negedge clk); eoi_valid = 0; idle(6);
    chk(hs_cnt - h, 1, "R11 eoi reopens");
    @(negedge clk); msg_ready = 0; eoi_valid = 1;
    @(negedge clk); eoi_valid = 0; idle(4);
    chk({31'h0, msg_valid}, 1, "R11 held before collision");
    @(negedge clk); msg_ready = 1; eoi_valid = 1;
    @(negedge clk); eoi_valid = 0; idle(6);
    rreg(8'h16, 32'h0000_E841, "R11 accept wins over eoi");
    irq_pin[3] = 1;
    @(negedge clk); eoi_valid = 1;
    @(negedge clk); eoi_valid = 0; idle(4);

    tag = "R9";
    h = hs_cnt;
    wreg(8'h18, 32'h0001_0044);
    pulse(4); idle(6);
    wreg(8'h18, 32'h0000_0044);
    idle(6);
    chk(hs_cnt - h, 0, "R9 masked edge discarded");
    tag = "R10";
    wreg(8'h1A, 32'h0000_0345);
    pulse(5); idle(6);
    wreg(8'h1A, 32'h0000_0645);
    pulse(5); idle(6);
    chk(hs_cnt - h, 0, "R10 reserved modes");
    tag = "R7";
    wreg(8'h1A, 32'h0000_2045);
    @(negedge clk); irq_pin[5] = 1; idle(4); irq_pin[5] = 0; idle(8);
    chk(hs_cnt - h, 1, "R7 active-low edge");

    done = 1;
    idle(2);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule